// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Sequencer

This block turns an external, active-low non-maskable interrupt pin into a complete processor entry sequence. The pin goes through a synchronizer and is then watched for a falling transition during normal running, or for a low level while the core sits in its low-power stop state. A detected request is held as pending until the core reaches an instruction boundary with an interrupt level mask above 15. The interrupt-enable flag of the status word has no say in this.

Once a request is taken, the sequencer saves the current status word and then the return address to the system stack through a single-word write port with a ready handshake. It then updates the stack pointer, status word and program counter in a single commit cycle. The status word gets a mask of 15 and a cleared stack-select flag. The program counter is loaded with the table base plus 0x3C0. The core treats `busy_o` as a hold on instruction issue and `done_o` as the point where fetch resumes at the new program counter.

Top module: `nmi_entry_seq`

## Requirements
- R1: While and after reset, with no request, `mem_wr_o`, `ssp_we_o`, `ps_we_o`, `pc_we_o`, `done_o` and `busy_o` are all 0.
- R2: With `stop_mode_i` low, each high-to-low transition of `nmi_n_i` produces exactly one entry sequence. Holding the pin low produces no further entries.
- R3: An entry starts only while the mask field `ps_i[20:16]` is greater than 15. With the field at 15 or below, no stack write takes place.
- R4: A detected request stays pending while it cannot be accepted. It is taken as soon as the mask rises above 15 at a boundary, and it clears only when its entry starts.
- R5: The interrupt-enable flag `ps_i[4]` has no effect on detection or acceptance.
- R6: The first stack write stores the status word at SSP-4. The second stores `next_pc_i` at SSP-8. Each write holds its address and data with `mem_wr_o` high until a cycle with `mem_rdy_i` high.
- R7: In the commit cycle `ssp_o` equals the stack pointer sampled at entry minus 8.
- R8: In the commit cycle `ps_o` equals the entry status word with bits 20:16 set to 15 and bit 5 (stack select) cleared, with all other bits unchanged.
- R9: In the commit cycle `pc_o` equals `tbr_i` plus 0x3C0. `done_o`, `pc_we_o`, `ps_we_o` and `ssp_we_o` are high together for exactly that one cycle.
- R10: With `stop_mode_i` high, a low level on `nmi_n_i` raises a request without any edge. Entries repeat for as long as the pin stays low.
- R11: When a request is already pending and the mask allows it, the first stack write is presented in the cycle right after `boundary_i` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_n_i | input | 1 | Asynchronous active-low interrupt pin |
| stop_mode_i | input | 1 | Core is in stop mode (level detection) |
| boundary_i | input | 1 | Core is at an instruction boundary and may be interrupted |
| ps_i | input | 32 | Current program status word |
| next_pc_i | input | 32 | Address of the next instruction |
| ssp_i | input | 32 | Current system stack pointer |
| tbr_i | input | 32 | Table base register |
| mem_wr_o | output | 1 | Stack write request |
| mem_addr_o | output | 32 | Stack write byte address |
| mem_wdata_o | output | 32 | Stack write data |
| mem_rdy_i | input | 1 | Stack write accepted this cycle |
| busy_o | output | 1 | Entry sequence in progress |
| ssp_we_o | output | 1 | Stack pointer write enable |
| ssp_o | output | 32 | New stack pointer |
| ps_we_o | output | 1 | Status word write enable |
| ps_o | output | 32 | New status word |
| pc_we_o | output | 1 | Program counter write enable |
| pc_o | output | 32 | New program counter |
| done_o | output | 1 | One-cycle pulse when the entry has finished |

## Verification
A pending bit stuck high or a wrong detection mode shows at the write port within a few cycles, as an entry nobody expects: a second entry while the pin stays low in normal mode, or an entry under a blocking mask. A pending bit that never sets shows as a missing entry, which the bench catches by waiting a bounded time for `done_o`. A fault in the sequencer's saved state or its order appears at the first or second accepted stack write, or in the single commit cycle, as a wrong address, data word, stack pointer, status word or vector. A write that breaks the handshake shows up as soon as ready is held low.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_PS = 2'd1,
      ST_PUSH_PC = 2'd2,
      ST_COMMIT  = 2'd3
   } nmi_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/nmi_pin_detect.sv
module nmi_pin_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   input  logic stop_i,
   output logic req_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("nmi_pin_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_s;
   logic                   fall;
   logic                   low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pin_s = sync_q[SYNC_STAGES-1];
   assign fall  = prev_q & ~pin_s;
   assign low   = ~pin_s;
   assign req_o = stop_i ? low : fall;

endmodule

// File: rtl/nmi_accept.sv
module nmi_accept #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned MASK_LSB     = 16,
   parameter int unsigned MASK_W       = 5,
   parameter int unsigned ACCEPT_ABOVE = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            boundary_i,
   input  logic            idle_i,
   input  logic [XLEN-1:0] ps_i,
   output logic            start_o
);

   generate
      if (MASK_LSB + MASK_W > XLEN) begin : g_bad_field
         $error("nmi_accept: mask field outside status word");
      end
      if (ACCEPT_ABOVE >= (1 << MASK_W) - 1) begin : g_bad_limit
         $error("nmi_accept: acceptance limit leaves no accepting value");
      end
   endgenerate

   logic [MASK_W-1:0] mask_lvl;
   logic              pending_q;
   logic              mask_ok;

   assign mask_lvl = ps_i[MASK_LSB +: MASK_W];
   assign mask_ok  = (32'(mask_lvl) > ACCEPT_ABOVE);
   assign start_o  = pending_q & boundary_i & idle_i & mask_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else begin
         pending_q <= req_i | (pending_q & ~start_o);
      end
   end

endmodule

// File: rtl/nmi_push_fsm.sv
module nmi_push_fsm
   import nmi_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned MASK_LSB  = 16,
   parameter int unsigned MASK_W    = 5,
   parameter int unsigned ENTRY_LVL = 15,
   parameter int unsigned SSEL_BIT  = 5,
   parameter logic [31:0] VEC_OFS   = 32'h0000_03C0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [XLEN-1:0] ps_i,
   input  logic [XLEN-1:0] next_pc_i,
   input  logic [XLEN-1:0] ssp_i,
   input  logic [XLEN-1:0] tbr_i,
   input  logic            mem_rdy_i,
   output logic            mem_wr_o,
   output logic [XLEN-1:0] mem_addr_o,
   output logic [XLEN-1:0] mem_wdata_o,
   output logic            idle_o,
   output logic            busy_o,
   output logic            ssp_we_o,
   output logic [XLEN-1:0] ssp_o,
   output logic            ps_we_o,
   output logic [XLEN-1:0] ps_o,
   output logic            pc_we_o,
   output logic [XLEN-1:0] pc_o,
   output logic            done_o
);

   localparam int unsigned WORD_BYTES = XLEN / BYTE_W;
   localparam logic [XLEN-1:0] STEP1 = XLEN'(WORD_BYTES);
   localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * WORD_BYTES);
   localparam logic [MASK_W-1:0] LVL = MASK_W'(ENTRY_LVL);

   generate
      if (XLEN % BYTE_W != 0) begin : g_bad_xlen
         $error("nmi_push_fsm: XLEN must be a whole number of bytes");
      end
      if (SSEL_BIT >= XLEN) begin : g_bad_ssel
         $error("nmi_push_fsm: stack-select bit outside status word");
      end
   endgenerate

   nmi_state_e      state_q, state_d;
   logic [XLEN-1:0] ps_q, pc_q, ssp_q, tbr_q;

   function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] s);
      logic [XLEN-1:0] r;
      r = s;
      r[MASK_LSB +: MASK_W] = LVL;
      r[SSEL_BIT] = 1'b0;
      return r;
   endfunction

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i)   state_d = ST_PUSH_PS;
         ST_PUSH_PS: if (mem_rdy_i) state_d = ST_PUSH_PC;
         ST_PUSH_PC: if (mem_rdy_i) state_d = ST_COMMIT;
         ST_COMMIT:                 state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ps_q    <= '0;
         pc_q    <= '0;
         ssp_q   <= '0;
         tbr_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            ps_q  <= ps_i;
            pc_q  <= next_pc_i;
            ssp_q <= ssp_i;
            tbr_q <= tbr_i;
         end
      end
   end

   always_comb begin
      mem_wr_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         ST_PUSH_PS: begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = ssp_q - STEP1;
            mem_wdata_o = ps_q;
         end
         ST_PUSH_PC: begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = ssp_q - STEP2;
            mem_wdata_o = pc_q;
         end
         default: ;
      endcase
   end

   assign idle_o   = (state_q == ST_IDLE);
   assign busy_o   = ~idle_o;
   assign done_o   = (state_q == ST_COMMIT);
   assign ssp_we_o = done_o;
   assign ps_we_o  = done_o;
   assign pc_we_o  = done_o;
   assign ssp_o    = ssp_q - STEP2;
   assign ps_o     = entry_status(ps_q);
   assign pc_o     = tbr_q + XLEN'(VEC_OFS);

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned MASK_LSB     = 16,
   parameter int unsigned MASK_W       = 5,
   parameter int unsigned ACCEPT_ABOVE = 15,
   parameter int unsigned ENTRY_LVL    = 15,
   parameter int unsigned SSEL_BIT     = 5,
   parameter logic [31:0] VEC_OFS      = 32'h0000_03C0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nmi_n_i,
   input  logic            stop_mode_i,
   input  logic            boundary_i,
   input  logic [XLEN-1:0] ps_i,
   input  logic [XLEN-1:0] next_pc_i,
   input  logic [XLEN-1:0] ssp_i,
   input  logic [XLEN-1:0] tbr_i,
   output logic            mem_wr_o,
   output logic [XLEN-1:0] mem_addr_o,
   output logic [XLEN-1:0] mem_wdata_o,
   input  logic            mem_rdy_i,
   output logic            busy_o,
   output logic            ssp_we_o,
   output logic [XLEN-1:0] ssp_o,
   output logic            ps_we_o,
   output logic [XLEN-1:0] ps_o,
   output logic            pc_we_o,
   output logic [XLEN-1:0] pc_o,
   output logic            done_o
);

   generate
      if (ENTRY_LVL > ACCEPT_ABOVE) begin : g_bad_entry
         $error("nmi_entry_seq: entry level would allow nested acceptance");
      end
   endgenerate

   logic req;
   logic start;
   logic idle;

   nmi_pin_detect #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n_i(nmi_n_i),
      .stop_i (stop_mode_i),
      .req_o  (req)
   );

   nmi_accept #(
      .XLEN        (XLEN),
      .MASK_LSB    (MASK_LSB),
      .MASK_W      (MASK_W),
      .ACCEPT_ABOVE(ACCEPT_ABOVE)
   ) u_accept (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .boundary_i(boundary_i),
      .idle_i    (idle),
      .ps_i      (ps_i),
      .start_o   (start)
   );

   nmi_push_fsm #(
      .XLEN     (XLEN),
      .MASK_LSB (MASK_LSB),
      .MASK_W   (MASK_W),
      .ENTRY_LVL(ENTRY_LVL),
      .SSEL_BIT (SSEL_BIT),
      .VEC_OFS  (VEC_OFS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .ps_i       (ps_i),
      .next_pc_i  (next_pc_i),
      .ssp_i      (ssp_i),
      .tbr_i      (tbr_i),
      .mem_rdy_i  (mem_rdy_i),
      .mem_wr_o   (mem_wr_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o),
      .idle_o     (idle),
      .busy_o     (busy_o),
      .ssp_we_o   (ssp_we_o),
      .ssp_o      (ssp_o),
      .ps_we_o    (ps_we_o),
      .ps_o       (ps_o),
      .pc_we_o    (pc_we_o),
      .pc_o       (pc_o),
      .done_o     (done_o)
   );

endmodule

// File: rtl/nmi_entry_checker.sv
module nmi_entry_checker #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned MASK_LSB     = 16,
   parameter int unsigned MASK_W       = 5,
   parameter int unsigned ACCEPT_ABOVE = 15,
   parameter int unsigned ENTRY_LVL    = 15,
   parameter int unsigned SSEL_BIT     = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] ps_i,
   input logic            mem_wr_o,
   input logic [XLEN-1:0] mem_addr_o,
   input logic [XLEN-1:0] mem_wdata_o,
   input logic            mem_rdy_i,
   input logic            busy_o,
   input logic            ssp_we_o,
   input logic [XLEN-1:0] ssp_o,
   input logic            ps_we_o,
   input logic [XLEN-1:0] ps_o,
   input logic            pc_we_o,
   input logic            done_o
);

   logic [XLEN-1:0] last_wr_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_wr_addr <= '0;
      else if (mem_wr_o && mem_rdy_i) last_wr_addr <= mem_addr_o;
   end

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> !mem_wr_o && !done_o && !busy_o);

   a_r3_mask_gates_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (32'($past(ps_i[MASK_LSB +: MASK_W])) > ACCEPT_ABOVE));

   a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o && !mem_rdy_i |=> mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

   a_r7_ssp_matches_last_push: assert property (@(posedge clk) disable iff (!rst_n)
      ssp_we_o |-> ssp_o == last_wr_addr);

   a_r8_status_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ps_we_o |-> (32'(ps_o[MASK_LSB +: MASK_W]) == ENTRY_LVL) && !ps_o[SSEL_BIT]);

   a_r9_commit_together: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> pc_we_o && ps_we_o && ssp_we_o && !mem_wr_o);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_first_write_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mem_wr_o);

endmodule

bind nmi_entry_seq nmi_entry_checker #(
   .XLEN        (XLEN),
   .MASK_LSB    (MASK_LSB),
   .MASK_W      (MASK_W),
   .ACCEPT_ABOVE(ACCEPT_ABOVE),
   .ENTRY_LVL   (ENTRY_LVL),
   .SSEL_BIT    (SSEL_BIT)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ps_i       (ps_i),
   .mem_wr_o   (mem_wr_o),
   .mem_addr_o (mem_addr_o),
   .mem_wdata_o(mem_wdata_o),
   .mem_rdy_i  (mem_rdy_i),
   .busy_o     (busy_o),
   .ssp_we_o   (ssp_we_o),
   .ssp_o      (ssp_o),
   .ps_we_o    (ps_we_o),
   .ps_o       (ps_o),
   .pc_we_o    (pc_we_o),
   .done_o     (done_o)
);

// File: tb/test_nmi_entry_seq.sv
`timescale 1ns/1ps
module test_nmi_entry_seq;

   typedef struct {
      bit          upd;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] c;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_n = 1'b1;
   logic        stop_mode = 1'b0;
   logic        boundary = 1'b1;
   logic [31:0] ps = 32'h001F_0020;
   logic [31:0] next_pc = 32'h0000_1000;
   logic [31:0] ssp = 32'h0000_8000;
   logic [31:0] tbr = 32'h000F_FC00;
   logic        mem_rdy = 1'b1;
   logic        mem_wr, busy, ssp_we, ps_we, pc_we, done;
   logic [31:0] mem_addr, mem_wdata, ssp_new, ps_new, pc_new;

   exp_t q[$];
   int   compared = 0;
   int   mismatched = 0;
   int   done_cnt = 0;
   int   wr_cnt = 0;
   bit   rdy_random = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   always #2 clk = ~clk;

   nmi_entry_seq i_nmi_entry_seq (
      .clk(clk), .rst_n(rst_n), .nmi_n_i(nmi_n), .stop_mode_i(stop_mode),
      .boundary_i(boundary), .ps_i(ps), .next_pc_i(next_pc), .ssp_i(ssp),
      .tbr_i(tbr), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .busy_o(busy),
      .ssp_we_o(ssp_we), .ssp_o(ssp_new), .ps_we_o(ps_we), .ps_o(ps_new),
      .pc_we_o(pc_we), .pc_o(pc_new), .done_o(done)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] status_after(input logic [31:0] s);
      logic [31:0] r;
      r = (s & ~(32'h1F << 16)) | (32'd15 << 16);
      r[5] = 1'b0;
      return r;
   endfunction

   // Driver: queue the writes and the commit one entry must produce
   task automatic expect_entry(input string tag);
      exp_t e;
      e.upd = 0; e.a = ssp - 32'd4; e.b = ps;      e.c = 0; e.tag = {tag, " R6 push status"};
      q.push_back(e);
      e.upd = 0; e.a = ssp - 32'd8; e.b = next_pc; e.c = 0; e.tag = {tag, " R6 push pc"};
      q.push_back(e);
      e.upd = 1; e.a = ssp - 32'd8; e.b = status_after(ps); e.c = tbr + 32'h3C0;
      e.tag = {tag, " R7 R8 R9 commit"};
      q.push_back(e);
   endtask

   // Ready driver, away from the sampling edge
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rdy <= rdy_random ? lfsr[0] : 1'b1;
   end

   // Monitor: pop and compare as the design produces results
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_wr && mem_rdy) begin
            wr_cnt++;
            if (q.size() == 0 || q[0].upd) begin
               check(1'b0, "R2 R3 unexpected stack write", mem_addr, 32'hx);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(mem_addr == e.a, {e.tag, " addr"}, mem_addr, e.a);
               check(mem_wdata == e.b, {e.tag, " data"}, mem_wdata, e.b);
            end
         end
         if (ssp_we || ps_we || pc_we || done) begin
            done_cnt++;
            check(ssp_we && ps_we && pc_we && done, "R9 commit strobes together",
                  {28'd0, ssp_we, ps_we, pc_we, done}, 32'hF);
            if (q.size() == 0 || !q[0].upd) begin
               check(1'b0, "R2 unexpected commit", pc_new, 32'hx);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(ssp_new == e.a, {e.tag, " ssp"}, ssp_new, e.a);
               check(ps_new == e.b, {e.tag, " status"}, ps_new, e.b);
               check(pc_new == e.c, {e.tag, " pc"}, pc_new, e.c);
            end
         end
      end
   end

   task automatic wait_done(input int target, input string tag);
      int t = 0;
      while (done_cnt < target && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(done_cnt >= target, tag, done_cnt, target);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      // R1: quiet during reset
      check({mem_wr, busy, ssp_we, ps_we, pc_we, done} == 6'b0, "R1 reset outputs",
            {26'd0, mem_wr, busy, ssp_we, ps_we, pc_we, done}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({mem_wr, busy, done} == 3'b0, "R1 idle after reset",
            {29'd0, mem_wr, busy, done}, 32'd0);

      // R2: one falling edge -> one entry; holding low adds none
      ps = 32'h001F_0030; next_pc = 32'h0000_1234; ssp = 32'h0000_8000; tbr = 32'h000F_FC00;
      expect_entry("T1 edge");
      nmi_n = 1'b0;
      wait_done(1, "R2 entry after falling edge");
      repeat (40) @(negedge clk);
      check(done_cnt == 1, "R2 held-low pin gives single entry", done_cnt, 1);
      nmi_n = 1'b1;
      repeat (6) @(negedge clk);

      // R3: mask at 15 blocks; R4 pending kept; R5 enable flag clear still taken
      rdy_random = 1'b1;
      ps = 32'h000F_0010;
      base = wr_cnt;
      nmi_n = 1'b0;
      repeat (30) @(negedge clk);
      check(wr_cnt == base && !busy, "R3 mask 15 blocks entry", wr_cnt, base);
      ps = 32'h0010_0020;
      next_pc = 32'h0000_2000; ssp = 32'h0000_7FF0; tbr = 32'h0001_0000;
      expect_entry("T2 R4 R5 latched");
      @(negedge clk);
      wait_done(2, "R4 pending request taken once mask rises");
      nmi_n = 1'b1;
      repeat (6) @(negedge clk);
      check(q.size() == 0, "R5 entry with enable flag clear", q.size(), 0);

      // R11: pending waits for boundary, then first write the next cycle
      boundary = 1'b0;
      ps = 32'h0018_00FF; next_pc = 32'h0000_3004; ssp = 32'h0000_4000; tbr = 32'h0000_0400;
      rdy_random = 1'b0;
      expect_entry("T3 boundary");
      nmi_n = 1'b0;
      repeat (10) @(negedge clk);
      check(!busy && !mem_wr, "R11 no entry off boundary", busy, 0);
      boundary = 1'b1;
      @(negedge clk);
      check(mem_wr && busy, "R11 first write one cycle after boundary", mem_wr, 1);
      check(mem_addr == 32'h0000_3FFC, "R6 first address below stack", mem_addr, 32'h0000_3FFC);
      wait_done(3, "R11 entry completes");
      nmi_n = 1'b1;
      repeat (6) @(negedge clk);

      // R10: stop mode, low level repeats entries
      stop_mode = 1'b1;
      rdy_random = 1'b1;
      ps = 32'h001F_FFFF; next_pc = 32'h0000_5000; ssp = 32'h0000_9000; tbr = 32'h0000_8000;
      repeat (8) @(negedge clk);
      check(done_cnt == 3 && !busy, "R10 stop mode pin high no entry", done_cnt, 3);
      expect_entry("T4 stop a");
      expect_entry("T4 stop b");
      expect_entry("T4 stop c");
      nmi_n = 1'b0;
      wait_done(5, "R10 level gives repeated entries");
      boundary = 1'b0;
      nmi_n = 1'b1;
      repeat (10) @(negedge clk);
      boundary = 1'b1;
      wait_done(6, "R10 pending entry after release");
      repeat (30) @(negedge clk);
      check(done_cnt == 6, "R10 no entry after pin released", done_cnt, 6);
      check(q.size() == 0, "R6 scoreboard drained", q.size(), 0);
      finish_run();
   end

endmodule